// File: doc/BRIEF.md
# Two-Register Accumulator Processor Core

This block is a small 8-bit processor core that runs one single-byte instruction per clock. Instructions come from a code store addressed by an instruction pointer. They operate on two working registers, a one-bit condition flag and a small data store. The core carries out the data movement, control flow, port I/O and housekeeping instructions itself. Arithmetic, comparison, logic, shift, multiply and divide opcodes go to an external execution unit. For those, the core shows the opcode and its current operands, and the unit returns new register and flag values together with write enables. These are applied on the same clock edge.

A host fills the code store through a preload write port, normally while the core is held in reset. The input port is a valid/ready byte source: reading a byte consumes it. The output port gives a one-cycle valid strobe with the data.

Top module: `acc8_core`

## Requirements
- R1: While the external reset `rst_n` is low, R0, R1, the flag C, every data-store byte and the instruction pointer read zero, and `out_valid`, `in_ready` and `exu_req` are low. Reset is applied asynchronously and released through a two-stage synchronizer, after which the first instruction is fetched from code address 0.
- R2: After each instruction the pointer moves to the next code address, wrapping from the top of the store to 0. Only a taken jump or the reset instruction changes this.
- R3: Opcode `00 m r aaaa` moves a byte between the data store at address `aaaa` and a register. With `m`=0 it loads into the register, with `m`=1 it stores the register. `r`=0 selects R0 and `r`=1 selects R1.
- R4: Opcode `01 h r iiii` writes `iiii` into the low nibble (`h`=0) or the high nibble (`h`=1) of the register chosen by `r`. The other nibble is kept.
- R5: `1111000r` copies R0 into R1 (`r`=0) or R1 into R0 (`r`=1). `11111100` exchanges R0 and R1. `1111100r` clears the chosen register.
- R6: `100000 r k` jumps to the address held in R0 (`r`=0) or R1 (`r`=1). With `k`=0 the jump is unconditional. With `k`=1 it is taken only when C is 1. `1111001v` writes the bit `v` into C.
- R7: `1111011r` reads the code-store byte at the address held in R0 and writes it into R0 (`r`=0) or R1 (`r`=1).
- R8: `11111101` sets C to the input port's valid and leaves the byte in place. `11111110` loads the waiting input byte into R0 and raises `in_ready` for that one cycle to consume it. When no byte is waiting it loads zero and leaves `in_ready` low.
- R9: `11111111` makes `out_valid` high for exactly the following cycle, with `out_data` equal to R0 as it was when the instruction ran.
- R10: `11110101` clears R0, R1, C and the whole data store and sends the pointer to address 0.
- R11: `11110100` and every opcode `1001xxxx` change nothing but the pointer, and they do not request the execution unit.
- R12: Opcodes `100001xx`, `101xxxxx`, `110xxxxx`, `1110xxxx` and `1111101x` raise `exu_req`. The returned R0, R1 and C are written where their enables are set.
- R13: A preload write stores `pl_data` at code address `pl_addr` on the clock edge. It is accepted while the core is in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pl_we | input | 1 | Code-store preload write enable |
| pl_addr | input | CODE_AW | Preload address |
| pl_data | input | 8 | Preload byte |
| exu_req | output | 1 | Current opcode belongs to the execution unit |
| exu_op | output | 8 | Current opcode |
| exu_a | output | 8 | R0 operand |
| exu_b | output | 8 | R1 operand |
| exu_cin | output | 1 | Current flag value |
| exu_r0 | input | 8 | Result for R0 |
| exu_r1 | input | 8 | Result for R1 |
| exu_cout | input | 1 | Result for C |
| exu_we0 | input | 1 | Write enable for R0 result |
| exu_we1 | input | 1 | Write enable for R1 result |
| exu_wec | input | 1 | Write enable for C result |
| in_valid | input | 1 | Input byte available |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte consumed this cycle |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | 8 | Output byte |

## Verification
On every cycle the assertions check how the pointer moves: it steps by one, goes to the register-held target on a taken jump, and returns to zero on the reset instruction. They also check that nibble immediates keep the other nibble, that undefined and no-operation opcodes leave R0, R1 and C alone, and that port strobes follow only from their opcodes. The results of whole instruction sequences can only be seen in the bench's programs. These are data-store round trips over every address, every byte value built from two nibbles, skipped and fall-through jump paths, table reads, execution-unit writes, port consumption, and the reset instruction wiping state that a later pass reads back.

// File: rtl/acc8_pkg.sv
`timescale 1ns/1ps
package acc8_pkg;
  localparam int W = 8;

  typedef enum logic [3:0] {
    K_NOP, K_LD, K_ST, K_IMM, K_JMP, K_EXU, K_COPY, K_SETC,
    K_RST, K_CLD, K_ZERO, K_SWAP, K_PRDY, K_PRD, K_PWR
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic       sel;   // register select / copy direction / flag value
    logic       hi;    // nibble select for immediates
    logic       cond;  // jump gated by flag
    logic [3:0] fld;   // data address or immediate
  } dec_t;
endpackage

// File: rtl/acc8_decode.sv
`timescale 1ns/1ps
module acc8_decode
  import acc8_pkg::*;
(
  input  logic [7:0] instr,
  output dec_t       dec
);
  always_comb begin
    dec.kind = K_NOP;
    dec.sel  = instr[0];
    dec.hi   = 1'b0;
    dec.cond = 1'b0;
    dec.fld  = instr[3:0];
    casez (instr)
      8'b00??????: begin
        dec.kind = instr[5] ? K_ST : K_LD;
        dec.sel  = instr[4];
      end
      8'b01??????: begin
        dec.kind = K_IMM;
        dec.hi   = instr[5];
        dec.sel  = instr[4];
      end
      8'b100000??: begin
        dec.kind = K_JMP;
        dec.sel  = instr[1];
        dec.cond = instr[0];
      end
      8'b100001??, 8'b101?????, 8'b110?????, 8'b1110????, 8'b1111101?:
        dec.kind = K_EXU;
      8'b1001????: dec.kind = K_NOP;
      8'b1111000?: dec.kind = K_COPY;
      8'b1111001?: dec.kind = K_SETC;
      8'b11110100: dec.kind = K_NOP;
      8'b11110101: dec.kind = K_RST;
      8'b1111011?: dec.kind = K_CLD;
      8'b1111100?: dec.kind = K_ZERO;
      8'b11111100: dec.kind = K_SWAP;
      8'b11111101: dec.kind = K_PRDY;
      8'b11111110: dec.kind = K_PRD;
      8'b11111111: dec.kind = K_PWR;
      default:     dec.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/acc8_code_mem.sv
`timescale 1ns/1ps
module acc8_code_mem #(
  parameter int AW = 8,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] fetch_addr,
  output logic [W-1:0]  fetch_data,
  input  logic [AW-1:0] tbl_addr,
  output logic [W-1:0]  tbl_data
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
  end

  assign fetch_data = store_q[fetch_addr];
  assign tbl_data   = store_q[tbl_addr];
endmodule

// File: rtl/acc8_data_mem.sv
`timescale 1ns/1ps
module acc8_data_mem #(
  parameter int AW = 4,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          run_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] cell_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge run_n) begin
      if (!run_n)                          cell_q[i] <= '0;
      else if (clr)                        cell_q[i] <= '0;
      else if (we && addr == AW'(i))       cell_q[i] <= wdata;
    end
  end

  assign rdata = cell_q[addr];
endmodule

// File: rtl/acc8_core.sv
`timescale 1ns/1ps
module acc8_core
  import acc8_pkg::*;
#(
  parameter int CODE_AW = 8,
  parameter int DATA_AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pl_we,
  input  logic [CODE_AW-1:0] pl_addr,
  input  logic [W-1:0]       pl_data,
  output logic               exu_req,
  output logic [W-1:0]       exu_op,
  output logic [W-1:0]       exu_a,
  output logic [W-1:0]       exu_b,
  output logic               exu_cin,
  input  logic [W-1:0]       exu_r0,
  input  logic [W-1:0]       exu_r1,
  input  logic               exu_cout,
  input  logic               exu_we0,
  input  logic               exu_we1,
  input  logic               exu_wec,
  input  logic               in_valid,
  input  logic [W-1:0]       in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [W-1:0]       out_data
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rsync_q;
  logic       run_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign run_n = rsync_q[1];

  // architectural state
  logic [CODE_AW-1:0] ip_q, ip_d;
  logic [W-1:0]       r0_q, r0_d, r1_q, r1_d;
  logic               c_q, c_d;
  logic               ov_q, ov_d;
  logic [W-1:0]       od_q, od_d;

  logic [W-1:0]       instr, tbl_byte, dm_rdata, dm_wdata;
  logic               dm_we, dm_clr;
  dec_t               dec;
  logic [W-1:0]       sel_reg, nib_val;

  acc8_code_mem #(.AW(CODE_AW), .W(W)) u_code (
    .clk        (clk),
    .we         (pl_we),
    .waddr      (pl_addr),
    .wdata      (pl_data),
    .fetch_addr (ip_q),
    .fetch_data (instr),
    .tbl_addr   (r0_q[CODE_AW-1:0]),
    .tbl_data   (tbl_byte)
  );

  acc8_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  acc8_data_mem #(.AW(DATA_AW), .W(W)) u_data (
    .clk   (clk),
    .run_n (run_n),
    .clr   (dm_clr),
    .we    (dm_we),
    .addr  (dec.fld[DATA_AW-1:0]),
    .wdata (dm_wdata),
    .rdata (dm_rdata)
  );

  assign sel_reg = dec.sel ? r1_q : r0_q;
  assign nib_val = dec.hi ? {dec.fld, sel_reg[3:0]} : {sel_reg[7:4], dec.fld};

  // next-state logic
  always_comb begin
    ip_d     = ip_q + 1'b1;
    r0_d     = r0_q;
    r1_d     = r1_q;
    c_d      = c_q;
    ov_d     = 1'b0;
    od_d     = od_q;
    dm_we    = 1'b0;
    dm_clr   = 1'b0;
    dm_wdata = sel_reg;
    in_ready = 1'b0;
    exu_req  = 1'b0;
    if (run_n) begin
      case (dec.kind)
        K_LD: begin
          if (dec.sel) r1_d = dm_rdata;
          else         r0_d = dm_rdata;
        end
        K_ST: dm_we = 1'b1;
        K_IMM: begin
          if (dec.sel) r1_d = nib_val;
          else         r0_d = nib_val;
        end
        K_JMP: begin
          if (!dec.cond || c_q) ip_d = sel_reg[CODE_AW-1:0];
        end
        K_EXU: begin
          exu_req = 1'b1;
          if (exu_we0) r0_d = exu_r0;
          if (exu_we1) r1_d = exu_r1;
          if (exu_wec) c_d  = exu_cout;
        end
        K_COPY: begin
          if (dec.sel) r0_d = r1_q;
          else         r1_d = r0_q;
        end
        K_SETC: c_d = dec.sel;
        K_RST: begin
          ip_d   = '0;
          r0_d   = '0;
          r1_d   = '0;
          c_d    = 1'b0;
          dm_clr = 1'b1;
        end
        K_CLD: begin
          if (dec.sel) r1_d = tbl_byte;
          else         r0_d = tbl_byte;
        end
        K_ZERO: begin
          if (dec.sel) r1_d = '0;
          else         r0_d = '0;
        end
        K_SWAP: begin
          r0_d = r1_q;
          r1_d = r0_q;
        end
        K_PRDY: c_d = in_valid;
        K_PRD: begin
          r0_d     = in_valid ? in_data : '0;
          in_ready = in_valid;
        end
        K_PWR: begin
          ov_d = 1'b1;
          od_d = r0_q;
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      ip_q <= '0;
      r0_q <= '0;
      r1_q <= '0;
      c_q  <= 1'b0;
      ov_q <= 1'b0;
      od_q <= '0;
    end else begin
      ip_q <= ip_d;
      r0_q <= r0_d;
      r1_q <= r1_d;
      c_q  <= c_d;
      ov_q <= ov_d;
      if (ov_d) od_q <= od_d;
    end
  end

  assign exu_op    = instr;
  assign exu_a     = r0_q;
  assign exu_b     = r1_q;
  assign exu_cin   = c_q;
  assign out_valid = ov_q;
  assign out_data  = od_q;
endmodule

// File: rtl/acc8_core_chk.sv
`timescale 1ns/1ps
module acc8_core_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          run_n,
  input logic [7:0]    instr,
  input logic [AW-1:0] ip,
  input logic [7:0]    r0,
  input logic [7:0]    r1,
  input logic          c,
  input logic          exu_req,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [7:0]    out_data
);
  logic is_jmp, is_rst, is_quiet, is_exu, is_imm_lo0;
  assign is_jmp     = (instr[7:2] == 6'b100000);
  assign is_rst     = (instr == 8'hF5);
  assign is_quiet   = (instr[7:4] == 4'b1001) || (instr == 8'hF4);
  assign is_exu     = (instr[7:2] == 6'b100001) || (instr[7:5] == 3'b101) ||
                      (instr[7:5] == 3'b110) || (instr[7:4] == 4'b1110) ||
                      (instr[7:1] == 7'b1111101);
  assign is_imm_lo0 = (instr[7:4] == 4'b0100);

  // R2: sequential step
  a_r2_ip_step: assert property (@(posedge clk) disable iff (!run_n)
    (!is_jmp && !is_rst) |=> ip == $past(ip) + 1'b1);

  // R6: taken jump lands on the register-held address
  a_r6_jump_target: assert property (@(posedge clk) disable iff (!run_n)
    (is_jmp && (!instr[0] || c)) |=> ip == $past(instr[1] ? r1[AW-1:0] : r0[AW-1:0]));

  // R6: gated jump with flag clear falls through
  a_r6_jump_skip: assert property (@(posedge clk) disable iff (!run_n)
    (is_jmp && instr[0] && !c) |=> ip == $past(ip) + 1'b1);

  // R10: reset instruction wipes registers and pointer
  a_r10_reset_instr: assert property (@(posedge clk) disable iff (!run_n)
    is_rst |=> (ip == '0 && r0 == 8'h00 && r1 == 8'h00 && !c));

  // R11: quiet opcodes keep the working state
  a_r11_quiet_hold: assert property (@(posedge clk) disable iff (!run_n)
    is_quiet |=> ($stable(r0) && $stable(r1) && $stable(c)));

  // R4: low-nibble immediate into R0 keeps the high nibble
  a_r4_nibble_keep: assert property (@(posedge clk) disable iff (!run_n)
    is_imm_lo0 |=> r0 == {$past(r0[7:4]), $past(instr[3:0])});

  // R9: output strobe follows only a port write, carrying old R0
  a_r9_out_strobe: assert property (@(posedge clk) disable iff (!run_n)
    out_valid |-> ($past(instr) == 8'hFF && out_data == $past(r0)));

  // R8: consumption only with a waiting byte and the read opcode
  a_r8_ready_cause: assert property (@(posedge clk) disable iff (!run_n)
    in_ready |-> (in_valid && instr == 8'hFE));

  // R12: execution-unit request matches its opcode classes
  a_r12_exu_class: assert property (@(posedge clk) disable iff (!run_n)
    exu_req == is_exu);
endmodule

bind acc8_core acc8_core_chk #(.AW(CODE_AW)) u_chk (
  .clk       (clk),
  .run_n     (run_n),
  .instr     (instr),
  .ip        (ip_q),
  .r0        (r0_q),
  .r1        (r1_q),
  .c         (c_q),
  .exu_req   (exu_req),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_acc8_core.sv
`timescale 1ns/1ps
module sim_acc8_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pl_we = 1'b0;
  logic [7:0] pl_addr = 8'h00;
  logic [7:0] pl_data = 8'h00;
  logic       exu_req, exu_cin, in_ready, out_valid;
  logic [7:0] exu_op, exu_a, exu_b, out_data;
  logic [7:0] exu_r0, exu_r1;
  logic       exu_cout, exu_we0, exu_we1, exu_wec;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;

  always #2.5 clk = ~clk;

  acc8_core u0 (
    .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .exu_req(exu_req), .exu_op(exu_op), .exu_a(exu_a), .exu_b(exu_b), .exu_cin(exu_cin),
    .exu_r0(exu_r0), .exu_r1(exu_r1), .exu_cout(exu_cout),
    .exu_we0(exu_we0), .exu_we1(exu_we1), .exu_wec(exu_wec),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data)
  );

  // execution-unit model: add (E4) and multiply (FB)
  logic [8:0]  sum9;
  logic [15:0] prod16;
  always_comb begin
    sum9     = {1'b0, exu_a} + {1'b0, exu_b};
    prod16   = exu_a * exu_b;
    exu_r0   = 8'h00; exu_r1 = 8'h00; exu_cout = 1'b0;
    exu_we0  = 1'b0;  exu_we1 = 1'b0; exu_wec = 1'b0;
    if (exu_op == 8'hE4) begin
      exu_r0 = sum9[7:0]; exu_cout = sum9[8]; exu_we0 = 1'b1; exu_wec = 1'b1;
    end else if (exu_op == 8'hFB) begin
      exu_r0 = prod16[15:8]; exu_r1 = prod16[7:0]; exu_we0 = 1'b1; exu_we1 = 1'b1;
    end
  end

  int nchk = 0;
  int nfail = 0;
  logic [7:0] prog [256];
  logic [7:0] expb [256];
  logic [7:0] ob [256];
  int plen, ne, oc, rdy, exn;

  task automatic chk8(input string rq, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", rq, act, exp);
    end
  endtask

  task automatic newp();
    plen = 0; ne = 0;
  endtask
  task automatic emit(input logic [7:0] b);
    prog[plen] = b; plen++;
  endtask
  task automatic li(input logic r, input logic [7:0] v);
    emit(8'h40 | {3'b000, r, v[3:0]});
    emit(8'h60 | {3'b000, r, v[7:4]});
  endtask
  task automatic patch(input int p, input logic r, input logic [7:0] v);
    prog[p]   = 8'h40 | {3'b000, r, v[3:0]};
    prog[p+1] = 8'h60 | {3'b000, r, v[7:4]};
  endtask
  task automatic expect_out(input logic [7:0] v);
    expb[ne] = v; ne++;
  endtask
  task automatic halt();
    li(1'b1, 8'(plen + 2));
    emit(8'h82);
  endtask

  // preload while in reset (R13), then run and compare the output stream
  task automatic go(input string rq);
    int cyc; int extra; logic drop;
    rst_n = 1'b0;
    for (int i = 0; i < plen; i++) begin
      @(negedge clk); pl_we = 1'b1; pl_addr = 8'(i); pl_data = prog[i];
    end
    @(negedge clk); pl_we = 1'b0;
    oc = 0; rdy = 0; exn = 0; drop = 1'b0;
    rst_n = 1'b1;
    cyc = 0; extra = 0;
    while (cyc < 4000 && extra < 8) begin
      @(negedge clk); cyc++;
      if (drop) begin in_valid = 1'b0; drop = 1'b0; end
      if (out_valid) begin if (oc < 256) ob[oc] = out_data; oc++; end
      if (in_ready) begin rdy++; drop = 1'b1; end
      if (exu_req) exn++;
      if (oc >= ne) extra++;
    end
    nchk++;
    if (oc < ne) begin
      nfail++;
      $display("FAIL %s R13 output count: got %0d expected %0d", rq, oc, ne);
    end
    for (int i = 0; i < ne; i++) chk8(rq, ob[i], expb[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int p, q;
    repeat (3) @(negedge clk);

    // R4 R2 R13: every byte value built from two nibbles, in four batches
    for (int b = 0; b < 4; b++) begin
      newp();
      for (int k = 0; k < 64; k++) begin
        li(1'b0, 8'(b * 64 + k)); emit(8'hFF); expect_out(8'(b * 64 + k));
      end
      halt();
      go("R4 immediate sweep");
    end

    // R4: other nibble kept, R1 path
    newp();
    li(1'b0, 8'hFF); emit(8'h40); emit(8'hFF); expect_out(8'hF0);
    emit(8'h60); emit(8'hFF); expect_out(8'h00);
    li(1'b0, 8'h5A); emit(8'h63); emit(8'hFF); expect_out(8'h3A);
    li(1'b1, 8'hC3); emit(8'hF1); emit(8'hFF); expect_out(8'hC3);
    halt();
    go("R4 nibble keep");

    // R3: every data address, both registers
    newp();
    for (int a = 0; a < 16; a++) begin
      li(1'b1, 8'(a * 17) ^ 8'hA5); emit(8'h30 | 8'(a));
    end
    for (int a = 0; a < 16; a++) begin
      emit(8'h00 | 8'(a)); emit(8'hFF); expect_out(8'(a * 17) ^ 8'hA5);
    end
    li(1'b0, 8'h6E); emit(8'h25); emit(8'h15); emit(8'hF8); emit(8'hF1); emit(8'hFF);
    expect_out(8'h6E);
    halt();
    go("R3 data store");

    // R5: swap, copy, zero; leaves C=1 and nonzero registers
    newp();
    li(1'b0, 8'h3C); li(1'b1, 8'hA5); emit(8'hFC); emit(8'hFF); expect_out(8'hA5);
    emit(8'hF1); emit(8'hFF); expect_out(8'h3C);
    li(1'b0, 8'h77); emit(8'hF0); li(1'b0, 8'h00); emit(8'hFC); emit(8'hFF); expect_out(8'h77);
    emit(8'hF9); emit(8'hFC); emit(8'hFF); expect_out(8'h00);
    li(1'b0, 8'hE1); emit(8'hF3);
    halt();
    go("R5 register moves");

    // R1: reset state with a byte waiting
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk8("R1 out_valid", {7'b0, out_valid}, 8'h00);
    chk8("R1 in_ready", {7'b0, in_ready}, 8'h00);
    chk8("R1 exu_req", {7'b0, exu_req}, 8'h00);
    chk8("R1 R0", exu_a, 8'h00);
    chk8("R1 R1", exu_b, 8'h00);
    chk8("R1 flag", {7'b0, exu_cin}, 8'h00);
    in_valid = 1'b0;

    // R6: gated and unconditional jumps
    newp();
    emit(8'hF3); p = plen; li(1'b1, 8'h00); emit(8'h83);
    li(1'b0, 8'h11); emit(8'hFF);
    patch(p, 1'b1, 8'(plen)); li(1'b0, 8'h22); emit(8'hFF); expect_out(8'h22);
    emit(8'hF2); p = plen; li(1'b1, 8'h00); emit(8'h83);
    li(1'b0, 8'h33); emit(8'hFF); expect_out(8'h33);
    patch(p, 1'b1, 8'(plen)); li(1'b0, 8'h44); emit(8'hFF); expect_out(8'h44);
    p = plen; li(1'b0, 8'h00); emit(8'h80);
    li(1'b0, 8'h55); emit(8'hFF);
    patch(p, 1'b0, 8'(plen)); li(1'b0, 8'h66); emit(8'hFF); expect_out(8'h66);
    halt();
    go("R6 jumps");

    // R12 R11: execution unit results and quiet opcodes
    newp();
    li(1'b0, 8'd200); li(1'b1, 8'd100); emit(8'hE4); emit(8'hFF); expect_out(8'h2C);
    p = plen; li(1'b1, 8'h00); emit(8'h83); li(1'b0, 8'h01); emit(8'hFF);
    patch(p, 1'b1, 8'(plen)); li(1'b0, 8'h02); emit(8'hFF); expect_out(8'h02);
    li(1'b0, 8'h12); li(1'b1, 8'h34); emit(8'hFB); emit(8'hFF); expect_out(8'h03);
    emit(8'hF1); emit(8'hFF); expect_out(8'hA8);
    li(1'b0, 8'h5A); emit(8'hF3);
    for (int k = 0; k < 16; k++) emit(8'h90 | 8'(k));
    emit(8'hF4); emit(8'hFF); expect_out(8'h5A);
    p = plen; li(1'b1, 8'h00); emit(8'h83); emit(8'hF8); emit(8'hFF);
    patch(p, 1'b1, 8'(plen)); emit(8'hFF); expect_out(8'h5A);
    halt();
    go("R12 exu and R11 quiet");
    chk8("R11 R12 exu request cycles", 8'(exn), 8'd2);

    // R7: table reads from code space
    newp();
    p = plen; li(1'b0, 8'h00); emit(8'hF7); emit(8'hF1); emit(8'hFF); expect_out(8'hB7);
    q = plen; li(1'b0, 8'h00); emit(8'hF6); emit(8'hFF); expect_out(8'hB7);
    li(1'b0, 8'h00); emit(8'hF6); emit(8'hFF); expect_out(8'h40);
    halt();
    patch(p, 1'b0, 8'(plen)); patch(q, 1'b0, 8'(plen));
    emit(8'hB7);
    go("R7 table read");

    // R8: input port empty
    newp();
    emit(8'hF3); emit(8'hFD); p = plen; li(1'b1, 8'h00); emit(8'h83);
    li(1'b0, 8'h10); emit(8'hFF); expect_out(8'h10);
    patch(p, 1'b1, 8'(plen)); li(1'b0, 8'h9C); emit(8'hFE); emit(8'hFF); expect_out(8'h00);
    halt();
    in_valid = 1'b0;
    go("R8 port empty");
    chk8("R8 no consume when empty", 8'(rdy), 8'd0);

    // R8 R9: input port with a byte waiting, consumed once
    newp();
    emit(8'hF2); emit(8'hFD); p = plen; li(1'b1, 8'h00); emit(8'h83);
    li(1'b0, 8'h10); emit(8'hFF);
    patch(p, 1'b1, 8'(plen)); emit(8'hFE); emit(8'hFF); expect_out(8'h77);
    li(1'b0, 8'h9C); emit(8'hFE); emit(8'hFF); expect_out(8'h00);
    halt();
    in_data = 8'h77; in_valid = 1'b1;
    go("R8 R9 port byte");
    chk8("R8 single consume", 8'(rdy), 8'd1);
    in_valid = 1'b0;

    // R10 R1: data store cleared by external reset, then by the reset opcode
    newp();
    emit(8'h03); emit(8'hFF); expect_out(8'h00);
    emit(8'hF1); emit(8'hFF); expect_out(8'h00);
    li(1'b0, 8'h05); emit(8'h23); li(1'b1, 8'h07); emit(8'hF3); emit(8'hF5);
    expect_out(8'h00); expect_out(8'h00);
    go("R10 reset opcode");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule